// File: doc/BRIEF.md
# Host Byte Mailbox Register Block

This block sits between a host register bus and a small external controller. It passes bytes in both directions through two byte queues: an outbound queue that the host fills and the controller drains, and an inbound queue that the controller fills and the host drains. The host sees three 32-bit registers: a request/enable register, a data register and a flag register. Every payload byte travels in bits 15:8 of the 32-bit word.

The host port is single-cycle. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from the current state while `reg_rd` is high, and any pop caused by that read happens at the same edge. On the controller side, outbound bytes use a valid/ready handshake. Inbound bytes arrive as a strobe that is never back-pressured: a byte that finds the inbound queue full is thrown away and leaves a sticky overflow flag. One interrupt line goes high whenever a request flag and its enable bit are both set.

Top module: `hostmbox_top`

## Requirements
- R1: After reset both queues are empty, all enable bits and the overflow flag are 0, and `irq` is 0. The flag register at offset 0x8 reads 0x3, and the request register at offset 0x0 reads 0x03.
- R2: A write to the data register at offset 0x4 queues `reg_wdata[15:8]` for output. While the outbound queue is not empty, `tx_valid` is 1 and `tx_data` shows the oldest byte. That byte is removed on a cycle with `tx_ready` high, and bytes leave in the order they were written.
- R3: The outbound queue holds 8 bytes. A data write that finds it full, with no outbound pop in the same cycle, is dropped.
- R4: A cycle with `rx_valid` high stores `rx_data` in the inbound queue. A read of offset 0x4 returns the oldest byte in bits 15:8, with every other bit 0, and removes that byte. Bytes come out in arrival order.
- R5: A read of offset 0x4 while the inbound queue is empty returns 0 and removes nothing.
- R6: The inbound queue holds 8 bytes. A byte that arrives when it is full is discarded and sets the overflow flag, unless a host pop happens in the same cycle, in which case the byte is stored and the flag is not set. The flag stays set until it is cleared.
- R7: The flag register has bit 0 = outbound empty, bit 1 = outbound not full, bit 2 = inbound not empty and bit 3 = overflow. Writing 1 to bit 3, either here or in the request register, clears the overflow flag. Writing back a value just read from this register therefore clears the flag. A new overflow in the same cycle as a clear leaves the flag set. Writes to bits 0..2 have no effect.
- R8: At offset 0x0, bits 3:0 read the four request flags in the same order as the flag register. Bits 7:4 are enable bits: they are written and read back. Bits 31:8 read 0.
- R9: `irq` is 1 exactly when at least one request flag has its enable bit set, in the same cycle as the state that causes it.
- R10: Offsets other than 0x0, 0x4 and 0x8 read 0. Writes to them have no effect, and reads of them do not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_data | output | 8 | Oldest outbound byte |
| tx_valid | output | 1 | Outbound queue not empty |
| tx_ready | input | 1 | Controller takes the outbound byte |
| rx_data | input | 8 | Inbound byte |
| rx_valid | input | 1 | Inbound byte strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two functions collide when a controller byte arrives at a full inbound queue in the same cycle as a host data read. The pop must make room, so the byte is kept and no overflow is flagged. The bench fills the queue to eight, drives `rx_valid` and a data read in one cycle, and then reads all eight remaining bytes back in order with the flag register clear. A second collision, an overflow in the same cycle as a clear write, is also provoked: the flag must survive.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int LANE_LO = 8;
    localparam int NSRC    = 4;
    localparam int OVF_BIT = 3;

    localparam logic [ADDR_W-1:0] OFS_REQ  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h08;

    typedef enum logic [1:0] {
        SEL_REQ,
        SEL_DATA,
        SEL_FLAG,
        SEL_NONE
    } reg_sel_e;

    // bit 0 first: outbound empty, outbound not full, inbound not empty, overflow
    typedef struct packed {
        logic rx_ovf;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } flags_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_REQ:  return SEL_REQ;
            OFS_DATA: return SEL_DATA;
            OFS_FLAG: return SEL_FLAG;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] lane_get(input logic [DATA_W-1:0] w);
        return w[LANE_LO +: BYTE_W];
    endfunction

    function automatic logic [DATA_W-1:0] lane_put(input logic [BYTE_W-1:0] b);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LANE_LO +: BYTE_W] = b;
        return w;
    endfunction
endpackage

// File: rtl/hostmbox_fifo.sv
module hostmbox_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dropped = push && !do_push;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hostmbox_irq.sv
module hostmbox_irq
    import hostmbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_empty,
    input  logic            tx_nfull,
    input  logic            rx_nempty,
    input  logic            ovf_set,
    input  logic            ovf_clr,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_din,
    output flags_t          req,
    output logic [NSRC-1:0] mask,
    output logic            irq
);
    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            mask  <= '0;
        end else begin
            if (ovf_set)      ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
            if (mask_we) mask <= mask_din;
        end
    end

    always_comb begin
        req.tx_empty  = tx_empty;
        req.tx_nfull  = tx_nfull;
        req.rx_nempty = rx_nempty;
        req.rx_ovf    = ovf_q;
    end

    assign irq = |(req & mask);
endmodule

// File: rtl/hostmbox_regif.sv
module hostmbox_regif
    import hostmbox_pkg::*;
(
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  flags_t            req,
    input  logic [NSRC-1:0]   mask,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_empty,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_pop,
    output logic              ovf_clr,
    output logic              mask_we,
    output logic [NSRC-1:0]   mask_din
);
    reg_sel_e sel;
    logic     unused_wbits;

    assign sel          = decode_sel(reg_addr);
    assign tx_byte      = lane_get(reg_wdata);
    assign mask_din     = reg_wdata[NSRC +: NSRC];
    assign unused_wbits = ^{reg_wdata[DATA_W-1:LANE_LO+BYTE_W], reg_wdata[OVF_BIT-1:0]};

    always_comb begin
        reg_rdata = '0;
        tx_push   = 1'b0;
        rx_pop    = 1'b0;
        ovf_clr   = 1'b0;
        mask_we   = 1'b0;
        case (sel)
            SEL_REQ: begin
                reg_rdata = {{(DATA_W-2*NSRC){1'b0}}, mask, req};
                mask_we   = reg_wr;
                ovf_clr   = reg_wr && reg_wdata[OVF_BIT];
            end
            SEL_DATA: begin
                reg_rdata = rx_empty ? '0 : lane_put(rx_head);
                rx_pop    = reg_rd && !rx_empty;
                tx_push   = reg_wr;
            end
            SEL_FLAG: begin
                reg_rdata = {{(DATA_W-NSRC){1'b0}}, req};
                ovf_clr   = reg_wr && reg_wdata[OVF_BIT];
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hostmbox_top.sv
module hostmbox_top
    import hostmbox_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              irq
);
    flags_t            req;
    logic [NSRC-1:0]   mask, mask_din;
    logic              tx_push, tx_empty, tx_full, tx_unused_drop;
    logic [BYTE_W-1:0] tx_byte, rx_head;
    logic              rx_pop, rx_empty, rx_full, rx_drop;
    logic              ovf_clr, mask_we;

    hostmbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .pop(tx_ready), .din(tx_byte),
        .dout(tx_data), .empty(tx_empty), .full(tx_full), .dropped(tx_unused_drop)
    );

    hostmbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_valid), .pop(rx_pop), .din(rx_data),
        .dout(rx_head), .empty(rx_empty), .full(rx_full), .dropped(rx_drop)
    );

    hostmbox_irq u_irq (
        .clk(clk), .rst(rst),
        .tx_empty(tx_empty), .tx_nfull(!tx_full), .rx_nempty(!rx_empty),
        .ovf_set(rx_drop), .ovf_clr(ovf_clr),
        .mask_we(mask_we), .mask_din(mask_din),
        .req(req), .mask(mask), .irq(irq)
    );

    hostmbox_regif u_regif (
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .req(req), .mask(mask), .rx_head(rx_head), .rx_empty(rx_empty),
        .reg_rdata(reg_rdata), .tx_push(tx_push), .tx_byte(tx_byte),
        .rx_pop(rx_pop), .ovf_clr(ovf_clr), .mask_we(mask_we), .mask_din(mask_din)
    );

    assign tx_valid = !tx_empty;
endmodule

// File: rtl/hostmbox_chk.sv
module hostmbox_chk
    import hostmbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic              ovf,
    input logic [NSRC-1:0]   mask,
    input logic              irq
);
    logic clr_wr;
    assign clr_wr = reg_wr && reg_wdata[OVF_BIT] &&
                    (reg_addr == OFS_FLAG || reg_addr == OFS_REQ);

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == OFS_DATA && rx_empty |-> reg_rdata == '0);

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_full && !rx_pop |=> ovf);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf && !clr_wr |=> ovf);

    // R9
    irq_tx_chk: assert property (@(posedge clk) disable iff (rst)
        mask[0] && !tx_valid |-> irq);
endmodule

bind hostmbox_top hostmbox_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_full(rx_full), .rx_pop(rx_pop), .rx_empty(rx_empty),
    .ovf(req.rx_ovf), .mask(mask), .irq(irq)
);

// File: tb/hostmbox_top_tb.sv
module hostmbox_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    hostmbox_top u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FIL%s %s actual=0x%0h expected=0x%0h", "", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        rd(5'h08, v); check("R1 flag reg", v, 32'h3);
        rd(5'h00, v); check("R1 request reg", v, 32'h03);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 tx_valid", {31'b0, tx_valid}, 0);

        // R2 R3 outbound sweep over fill levels
        for (int n = 0; n <= 10; n++) begin
            int kept;
            kept = (n < 8) ? n : 8;
            do_reset();
            for (int i = 0; i < n; i++)
                wr(5'h04, 32'hA5A5_00A5 | (32'((n * 16 + i + 1) & 8'hFF) << 8));
            rd(5'h08, v);
            check("R7 outbound flags", v & 32'h3, {30'b0, (n < 8), (n == 0)});
            for (int i = 0; i < kept; i++) begin
                @(negedge clk);
                check(n > 8 ? "R3 kept byte" : "R2 byte order", {24'b0, tx_data},
                      32'((n * 16 + i + 1) & 8'hFF));
                check("R2 tx_valid", {31'b0, tx_valid}, 1);
                tx_ready = 1'b1;
                @(negedge clk);
                tx_ready = 1'b0;
            end
            #1 check("R3 drained", {31'b0, tx_valid}, 0);
        end

        // R4 R5 R6 R7 inbound sweep
        for (int n = 0; n <= 10; n++) begin
            int kept;
            kept = (n < 8) ? n : 8;
            do_reset();
            for (int i = 0; i < n; i++) rx_send(8'(8'h40 + n * 11 + i));
            rd(5'h08, v);
            check("R6 overflow flag", v, {28'b0, (n > 8), (n > 0), 2'b11});
            for (int i = 0; i < kept; i++) begin
                logic [31:0] d;
                rd(5'h04, d);
                check("R4 inbound byte", d, 32'(8'(8'h40 + n * 11 + i)) << 8);
            end
            rd(5'h04, v); check("R5 empty read", v, 0);
            wr(5'h08, {28'b0, (n > 8), 3'b011});
            rd(5'h08, v); check("R7 write-back clears", v, 32'h3);
        end

        // R5 empty read pops nothing
        do_reset();
        rd(5'h04, v);
        rx_send(8'h5C);
        rd(5'h04, v); check("R5 no pop on empty", v, 32'h5C00);

        // R6 arrival at full queue with same-cycle pop
        do_reset();
        for (int i = 0; i < 8; i++) rx_send(8'(8'h10 + i));
        @(negedge clk);
        reg_addr = 5'h04; reg_rd = 1'b1; rx_data = 8'h99; rx_valid = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; rx_valid = 1'b0;
        check("R6 pop data", v, 32'h1000);
        rd(5'h08, v); check("R6 no overflow with pop", v, 32'h7);
        for (int i = 1; i <= 8; i++) begin
            logic [31:0] d;
            rd(5'h04, d);
            check("R6 order after collision", d, (i == 8) ? 32'h9900 : (32'(8'h10 + i) << 8));
        end

        // R7 set beats clear; bits 0..2 not writable; clear via request reg
        do_reset();
        for (int i = 0; i < 8; i++) rx_send(8'(i));
        @(negedge clk);
        reg_addr = 5'h08; reg_wdata = 32'h8; reg_wr = 1'b1; rx_data = 8'hEE; rx_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0;
        rd(5'h08, v); check("R7 set wins over clear", v, 32'hF);
        wr(5'h08, 32'h7);
        rd(5'h08, v); check("R7 low bits ignore writes", v, 32'hF);
        wr(5'h00, 32'h8);
        rd(5'h08, v); check("R7 clear via request reg", v, 32'h7);

        // R8 R9 enable sweep, req = 0111 then 1111
        for (int ph = 0; ph < 2; ph++) begin
            int rq;
            do_reset();
            rx_send(8'h01);
            if (ph == 1) for (int i = 0; i < 8; i++) rx_send(8'h02);
            rq = (ph == 1) ? 15 : 7;
            for (int m = 0; m < 16; m++) begin
                wr(5'h00, 32'hFFFF_FF00 | 32'(m << 4) | ((ph == 1) ? 32'h0 : 32'h8));
                rd(5'h00, v); check("R8 request reg", v, 32'((m << 4) | rq));
                check("R9 irq", {31'b0, irq}, {31'b0, (m & rq) != 0});
            end
        end
        // R9 irq follows outbound not-empty clearing
        do_reset();
        wr(5'h00, 32'h10);
        check("R9 irq empty", {31'b0, irq}, 1);
        wr(5'h04, 32'h0000_3300);
        #1 check("R9 irq drops", {31'b0, irq}, 0);

        // R10 reserved offsets
        do_reset();
        rx_send(8'h77);
        for (int a = 12; a < 32; a += 4) begin
            wr(5'(a), 32'hFFFF_FFFF);
            rd(5'(a), v); check("R10 reserved reads 0", v, 0);
        end
        rd(5'h00, v); check("R10 request reg untouched", v, 32'h07);
        check("R10 no tx push", {31'b0, tx_valid}, 0);
        rd(5'h04, v); check("R10 no pop", v, 32'h7700);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule